// File: doc/BRIEF.md
# Two-Cell Battery Protection Sequencer

A synchronous controller for a pack of two cells in series. Comparators outside the block give, for each cell, four digitized flags: above the overcharge trip level, above the overcharge-release level, below the overdischarge trip level and below the overdischarge-release level. A fifth flag per cell says whether that cell is higher than its partner. The block also takes a 3-bit discharge-current sense code, a charger-present flag, a load-released flag and a timebase strobe with one pulse per time unit. By default one unit is 10 µs.

Every fault must persist for its own delay, counted in timebase units, before it is acted on. An overcharge turns the charge switch off. The overcharged cell is bled until it has come down to its partner, or to the release level when the partner is low. An overdischarge turns the discharge switch off and puts the block into power-down. Power-down ends only when the charger is seen. An overcurrent trips after a delay that gets shorter as the sense code rises. It then keeps discharge off for a minimum lockout, and releases only when the load has been removed. All outputs are registered and change on the clock edge that sees the qualifying timebase pulse.

Top module: `pack_guard`

## Requirements
- R1: When `cell_ov_i[k]` has been high on OV_DLY consecutive timebase pulses, `chg_en_o` goes low on the edge that sees the last of those pulses.
- R2: A latched overcharge of cell k ends on the first edge on which `cell_ocr_i[k]` is low, with no delay. `chg_en_o` returns high once no cell is latched.
- R3: When any bit of `cell_uv_i` has been high on UV_DLY consecutive timebase pulses, `dsg_en_o` goes low and `pd_o` goes high on the edge that sees the last pulse.
- R4: A latched overdischarge ends on the first edge outside power-down on which `cell_odr_i` is all zero. `dsg_en_o` then rises, unless an overcurrent is latched.
- R5: While `pd_o` is high, neither the overdischarge timer nor the overcurrent timer runs. The first edge with `chg_det_i` high clears `pd_o`.
- R6: Sense code 0 means the current is below the threshold. Codes 1 to 7 select overcurrent delays OC_DLY[0..6], which default to 900, 560, 280, 200, 54, 29 and 27 units. The trip happens on the timebase pulse at which the time spent above the threshold reaches the delay of the code now present.
- R7: After an overcurrent trip, `dsg_en_o` stays low for at least LOCK_DLY timebase pulses (default 25600). After that it rises on the first edge with `load_rel_i` high.
- R8: `bleed_o[k]` is high while cell k is latched overcharged and either `cell_hi_i[k]` is high or the partner's `cell_ocr_i` is low.
- R9: Overcharge qualification, overcharge release and bleeding keep running during power-down.
- R10: A delay count restarts from zero when its condition drops out before the delay is complete. An edge without a timebase pulse leaves the count unchanged.
- R11: During reset and after it, `chg_en_o` and `dsg_en_o` are high and `bleed_o` and `pd_o` are low.
- R12: If the overdischarge and the overcurrent delays complete on the same edge, only the overdischarge is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_tick_i | input | 1 | One-cycle strobe per timebase unit |
| cell_ov_i | input | 2 | Cell above the overcharge trip level |
| cell_ocr_i | input | 2 | Cell above the overcharge-release level |
| cell_uv_i | input | 2 | Cell below the overdischarge trip level |
| cell_odr_i | input | 2 | Cell below the overdischarge-release level |
| cell_hi_i | input | 2 | Cell higher than its partner |
| sense_lvl_i | input | 3 | Discharge-current sense code, 0 = below threshold |
| chg_det_i | input | 1 | Charger present (sense below the negative threshold) |
| load_rel_i | input | 1 | Load removed from the pack terminals |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| bleed_o | output | 2 | Per-cell balance bleed enable |
| pd_o | output | 1 | Power-down request |

## Verification
Every output is registered from the same next-state logic that it reports. A trip, a release or a wake is therefore visible right after the clock edge that takes in the qualifying input or timebase pulse, with no further latency. The bench changes inputs on the falling edge. It advances its behavioural model on the rising edge from those inputs and compares all five outputs at the next falling edge. This places each check exactly one register stage after its stimulus. The delays are reduced through parameters so that each boundary can be reached. The tests cover a count that stops one pulse short, a timebase with gaps, and a sense code that rises in the middle of a count.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int SENSE_W = 3;
  localparam int N_LVL   = (1 << SENSE_W) - 1;

  typedef int unsigned dly_tab_t [N_LVL];

  // largest of a delay table and three scalar delays
  function automatic int unsigned dly_max(dly_tab_t tab, int unsigned a,
                                          int unsigned b, int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    for (int i = 0; i < N_LVL; i++) if (tab[i] > m) m = tab[i];
    return m;
  endfunction
endpackage

// File: rtl/pg_timer.sv
// Qualification counter: counts timebase pulses while run is high and
// flags done on the pulse at which the elapsed count reaches limit.
module pg_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt;
  logic [TW:0]   nxt;

  assign nxt  = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
  assign done = run && tick && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick)
      cnt <= done ? '0 : nxt[TW-1:0];
  end
endmodule

// File: rtl/pg_cell.sv
// Per-cell overcharge latch with its qualification timer.
module pg_cell #(
  parameter int          TW     = 16,
  parameter int unsigned OV_DLY = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ov,
  input  logic ocr,
  output logic ovc_q,
  output logic ovc_n
);
  logic trip;

  pg_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .run   (ov && !ovc_q),
    .limit (TW'(OV_DLY)),
    .done  (trip)
  );

  // release is immediate once the cell drops under the release level
  assign ovc_n = ovc_q ? ocr : trip;

  always_ff @(posedge clk) begin
    if (rst) ovc_q <= 1'b0;
    else     ovc_q <= ovc_n;
  end
endmodule

// File: rtl/pg_surge.sv
// Overcurrent path: inverse-time qualification and minimum lockout.
module pg_surge
  import pg_pkg::*;
#(
  parameter int          TW       = 16,
  parameter int unsigned LOCK_DLY = 25600,
  parameter dly_tab_t    OC_DLY   = '{900, 560, 280, 200, 54, 29, 27}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               enable,
  input  logic               veto,
  input  logic [SENSE_W-1:0] lvl,
  input  logic               load_rel,
  output logic               ocf_q,
  output logic               ocf_n
);
  logic [TW-1:0] tab [N_LVL];
  logic [TW-1:0] limit;
  logic [TW-1:0] lk;
  logic          lk_done;
  logic          run;
  logic          done;

  genvar gi;
  generate
    for (gi = 0; gi < N_LVL; gi++) begin : g_tab
      assign tab[gi] = TW'(OC_DLY[gi]);
    end
  endgenerate

  always_comb begin
    limit = '1;
    if (lvl != '0) limit = tab[lvl - SENSE_W'(1)];
  end

  assign run = enable && !ocf_q && (lvl != '0);

  pg_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .run   (run),
    .limit (limit),
    .done  (done)
  );

  assign lk_done = (lk == TW'(LOCK_DLY));
  assign ocf_n   = ocf_q ? !(lk_done && load_rel) : (done && !veto);

  always_ff @(posedge clk) begin
    if (rst) begin
      ocf_q <= 1'b0;
      lk    <= '0;
    end else begin
      ocf_q <= ocf_n;
      if (!ocf_q)              lk <= '0;
      else if (tick && !lk_done) lk <= lk + TW'(1);
    end
  end
endmodule

// File: rtl/pack_guard.sv
module pack_guard
  import pg_pkg::*;
#(
  parameter int unsigned OV_DLY   = 2500,
  parameter int unsigned UV_DLY   = 2500,
  parameter int unsigned LOCK_DLY = 25600,
  parameter dly_tab_t    OC_DLY   = '{900, 560, 280, 200, 54, 29, 27}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               unit_tick_i,
  input  logic [1:0]         cell_ov_i,
  input  logic [1:0]         cell_ocr_i,
  input  logic [1:0]         cell_uv_i,
  input  logic [1:0]         cell_odr_i,
  input  logic [1:0]         cell_hi_i,
  input  logic [SENSE_W-1:0] sense_lvl_i,
  input  logic               chg_det_i,
  input  logic               load_rel_i,
  output logic               chg_en_o,
  output logic               dsg_en_o,
  output logic [1:0]         bleed_o,
  output logic               pd_o
);
  localparam int unsigned TMAX = dly_max(OC_DLY, OV_DLY, UV_DLY, LOCK_DLY);
  localparam int          TW   = $clog2(TMAX + 1) + 1;

  logic [1:0] ovc_q, ovc_n;
  logic       uvf_q, uvf_n;
  logic       pd_n;
  logic       uv_trip;
  logic       ocf_q, ocf_n;
  logic [1:0] bleed_n;

  genvar gc;
  generate
    for (gc = 0; gc < 2; gc++) begin : g_cell
      pg_cell #(.TW(TW), .OV_DLY(OV_DLY)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .tick  (unit_tick_i),
        .ov    (cell_ov_i[gc]),
        .ocr   (cell_ocr_i[gc]),
        .ovc_q (ovc_q[gc]),
        .ovc_n (ovc_n[gc])
      );
      assign bleed_n[gc] = ovc_n[gc] && (cell_hi_i[gc] || !cell_ocr_i[1-gc]);
    end
  endgenerate

  pg_timer #(.TW(TW)) u_uv_tmr (
    .clk   (clk),
    .rst   (rst),
    .tick  (unit_tick_i),
    .run   (!pd_o && !uvf_q && (|cell_uv_i)),
    .limit (TW'(UV_DLY)),
    .done  (uv_trip)
  );

  pg_surge #(.TW(TW), .LOCK_DLY(LOCK_DLY), .OC_DLY(OC_DLY)) u_surge (
    .clk      (clk),
    .rst      (rst),
    .tick     (unit_tick_i),
    .enable   (!pd_o && !uvf_q),
    .veto     (uv_trip),
    .lvl      (sense_lvl_i),
    .load_rel (load_rel_i),
    .ocf_q    (ocf_q),
    .ocf_n    (ocf_n)
  );

  assign pd_n  = pd_o  ? !chg_det_i : uv_trip;
  assign uvf_n = uvf_q ? (pd_o || (|cell_odr_i)) : uv_trip;

  always_ff @(posedge clk) begin
    if (rst) begin
      uvf_q    <= 1'b0;
      pd_o     <= 1'b0;
      chg_en_o <= 1'b1;
      dsg_en_o <= 1'b1;
      bleed_o  <= 2'b00;
    end else begin
      uvf_q    <= uvf_n;
      pd_o     <= pd_n;
      chg_en_o <= !(|ovc_n);
      dsg_en_o <= !(uvf_n || ocf_n);
      bleed_o  <= bleed_n;
    end
  end
endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk #(
  parameter int unsigned LOCK_DLY = 25600
) (
  input logic       clk,
  input logic       rst,
  input logic       unit_tick_i,
  input logic [1:0] cell_ov_i,
  input logic [1:0] cell_ocr_i,
  input logic       chg_det_i,
  input logic       chg_en_o,
  input logic [1:0] bleed_o,
  input logic       pd_o,
  input logic       ocf_q
);
  int unsigned held;

  always_ff @(posedge clk) begin
    if (rst || !ocf_q)                    held <= 0;
    else if (unit_tick_i && held < LOCK_DLY) held <= held + 1;
  end

  p_chg_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(chg_en_o) |-> $past(|cell_ov_i));

  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    (!(|cell_ocr_i) && !(|cell_ov_i)) |=> chg_en_o);

  p_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (pd_o && chg_det_i) |=> !pd_o);

  p_no_oc_in_pd_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ocf_q) |-> !$past(pd_o));

  p_lockout_r7: assert property (@(posedge clk) disable iff (rst)
    (ocf_q && held < LOCK_DLY) |=> ocf_q);

  p_bleed_latched_r8: assert property (@(posedge clk) disable iff (rst)
    (|bleed_o) |-> !chg_en_o);

  p_uv_first_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_o) |-> !$rose(ocf_q));
endmodule

bind pack_guard pack_guard_chk #(.LOCK_DLY(LOCK_DLY)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .unit_tick_i (unit_tick_i),
  .cell_ov_i   (cell_ov_i),
  .cell_ocr_i  (cell_ocr_i),
  .chg_det_i   (chg_det_i),
  .chg_en_o    (chg_en_o),
  .bleed_o     (bleed_o),
  .pd_o        (pd_o),
  .ocf_q       (ocf_q)
);

// File: tb/pack_guard_tb.sv
`timescale 1ns/1ps
module pack_guard_tb;
  localparam int OVD  = 20;
  localparam int UVD  = 30;
  localparam int LOCK = 200;
  localparam int unsigned TAB [7] = '{90, 56, 28, 20, 6, 4, 3};

  logic clk = 0, rst = 1, tick = 1;
  logic [1:0] ov = 0, ocr = 0, uv = 0, odr = 0, hi = 0;
  logic [2:0] lvl = 0;
  logic chg = 0, lrel = 0;
  logic chg_en, dsg_en, pd;
  logic [1:0] bleed;

  pack_guard #(.OV_DLY(OVD), .UV_DLY(UVD), .LOCK_DLY(LOCK),
               .OC_DLY('{90, 56, 28, 20, 6, 4, 3})) u_dut (
    .clk(clk), .rst(rst), .unit_tick_i(tick), .cell_ov_i(ov),
    .cell_ocr_i(ocr), .cell_uv_i(uv), .cell_odr_i(odr), .cell_hi_i(hi),
    .sense_lvl_i(lvl), .chg_det_i(chg), .load_rel_i(lrel),
    .chg_en_o(chg_en), .dsg_en_o(dsg_en), .bleed_o(bleed), .pd_o(pd));

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit gap = 0, fin = 0;
  string tag = "R11";

  // reference model state
  int m_ovc [2], m_ovcnt [2];
  int m_uvf, m_pd, m_uvcnt, m_ocf, m_occnt, m_lk;
  int e_chg = 1, e_dsg = 1, e_pd = 0;
  int e_bl [2] = '{0, 0};

  always @(posedge clk) begin
    int n_ovc [2];
    int uvrun, uvdone, ocrun, ocdone, trip, n_pd, n_uvf, n_ocf;
    if (rst) begin
      m_ovc = '{0, 0}; m_ovcnt = '{0, 0};
      m_uvf = 0; m_pd = 0; m_uvcnt = 0; m_ocf = 0; m_occnt = 0; m_lk = 0;
      e_chg = 1; e_dsg = 1; e_pd = 0; e_bl = '{0, 0};
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (m_ovc[k] != 0) begin
          n_ovc[k] = ocr[k]; m_ovcnt[k] = 0;
        end else if (!ov[k]) begin
          n_ovc[k] = 0; m_ovcnt[k] = 0;
        end else begin
          n_ovc[k] = (tick && m_ovcnt[k] + 1 >= OVD) ? 1 : 0;
          if (tick) m_ovcnt[k] = (n_ovc[k] != 0) ? 0 : m_ovcnt[k] + 1;
        end
      end
      uvrun  = (m_pd == 0 && m_uvf == 0 && uv != 0) ? 1 : 0;
      uvdone = (uvrun != 0 && tick && m_uvcnt + 1 >= UVD) ? 1 : 0;
      if (uvrun == 0) m_uvcnt = 0;
      else if (tick) m_uvcnt = (uvdone != 0) ? 0 : m_uvcnt + 1;
      ocrun  = (m_pd == 0 && m_uvf == 0 && m_ocf == 0 && lvl != 0) ? 1 : 0;
      ocdone = (ocrun != 0 && tick && m_occnt + 1 >= int'(TAB[lvl-1])) ? 1 : 0;
      if (ocrun == 0) m_occnt = 0;
      else if (tick) m_occnt = (ocdone != 0) ? 0 : m_occnt + 1;
      trip = (ocdone != 0 && uvdone == 0) ? 1 : 0;
      if (m_ocf != 0) n_ocf = (m_lk == LOCK && lrel) ? 0 : 1;
      else            n_ocf = trip;
      if (m_ocf == 0) m_lk = 0;
      else if (tick && m_lk < LOCK) m_lk = m_lk + 1;
      n_pd  = (m_pd != 0) ? (chg ? 0 : 1) : uvdone;
      n_uvf = (m_uvf != 0) ? ((m_pd != 0 || odr != 0) ? 1 : 0) : uvdone;
      m_ovc = n_ovc; m_pd = n_pd; m_uvf = n_uvf; m_ocf = n_ocf;
      e_chg = (n_ovc[0] == 0 && n_ovc[1] == 0) ? 1 : 0;
      e_dsg = (n_uvf == 0 && n_ocf == 0) ? 1 : 0;
      e_pd  = n_pd;
      for (int k = 0; k < 2; k++)
        e_bl[k] = (n_ovc[k] != 0 && (hi[k] || !ocr[1-k])) ? 1 : 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // compare against the model every cycle, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (!fin) begin
      chk("chg_en", int'(chg_en), e_chg);
      chk("dsg_en", int'(dsg_en), e_dsg);
      chk("pd", int'(pd), e_pd);
      chk("bleed0", int'(bleed[0]), e_bl[0]);
      chk("bleed1", int'(bleed[1]), e_bl[1]);
    end
    tick <= gap ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    tag = "R11";
    chk("reset chg_en", int'(chg_en), 1);
    chk("reset dsg_en", int'(dsg_en), 1);
    chk("reset bleed", int'(bleed), 0);
    rst = 0;
    step(3);
    chk("post-reset pd", int'(pd), 0);

    // R1 / R8: cell 0 overcharged, higher than its partner
    tag = "R1";
    ocr = 2'b11; ov = 2'b01; hi = 2'b01;
    step(OVD - 1);
    chk("one pulse short", int'(chg_en), 1);
    step(1);
    chk("tripped", int'(chg_en), 0);
    tag = "R8";
    step(1);
    chk("bleed on", int'(bleed[0]), 1);
    ov = 0; step(3);
    hi = 0; step(2);
    chk("balanced, partner above release", int'(bleed[0]), 0);
    tag = "R2";
    ocr = 2'b10; step(1);
    chk("immediate release", int'(chg_en), 1);
    step(3);

    // R10: dropouts restart the count, gaps hold it
    tag = "R10";
    ocr = 2'b11;
    ov = 2'b10; step(10); ov = 0; step(2);
    ov = 2'b10; step(15); ov = 0; step(2);
    chk("no trip after broken runs", int'(chg_en), 1);
    gap = 1; ov = 2'b10; step(35);
    chk("trip with gapped timebase", int'(chg_en), 0);
    gap = 0;

    // R8: partner below release keeps bleeding while equal
    tag = "R8";
    ov = 2'b10; hi = 2'b00; ocr = 2'b10; step(4);
    ov = 0; step(4);
    chk("bleed while partner low", int'(bleed[1]), 1);
    tag = "R2";
    ocr = 2'b00; step(3);
    chk("released", int'(chg_en), 1);

    // R6 / R7: every sense code
    for (int l = 1; l <= 7; l++) begin
      tag = "R6";
      lvl = 3'(l); step(int'(TAB[l-1]) + 3);
      chk("overcurrent trip", int'(dsg_en), 0);
      tag = "R7";
      lvl = 0; lrel = 1; step(LOCK - 10);
      chk("still locked", int'(dsg_en), 0);
      step(15);
      chk("released after lockout", int'(dsg_en), 1);
      lrel = (l == 3);
      step(2);
    end
    tag = "R7";
    lrel = 0;
    lvl = 7; step(10); lvl = 0; step(LOCK + 10);
    chk("waits for load release", int'(dsg_en), 0);
    lrel = 1; step(2); lrel = 0;
    chk("load released", int'(dsg_en), 1);

    // R6: short burst, then rising code mid-count
    tag = "R6";
    lvl = 1; step(50); lvl = 0; step(3);
    chk("short burst ignored", int'(dsg_en), 1);
    lvl = 1; step(30); lvl = 4; step(2);
    chk("rising code trips at once", int'(dsg_en), 0);
    lvl = 0; lrel = 1; step(LOCK + 5); lrel = 0; step(2);

    // R12: both delays finish together
    tag = "R12";
    odr = 2'b01; uv = 2'b01; step(UVD - 3);
    lvl = 7; step(6);
    chk("power-down entered", int'(pd), 1);
    tag = "R5";
    step(50);
    chk("no overcurrent in power-down", int'(dsg_en), 0);
    uv = 0; step(5);
    chk("stays down without charger", int'(pd), 1);

    // R9: overcharge path still runs in power-down
    tag = "R9";
    ocr = 2'b10; ov = 2'b10; hi = 2'b10; step(OVD + 2);
    chk("overcharge in power-down", int'(chg_en), 0);
    chk("bleed in power-down", int'(bleed[1]), 1);
    ov = 0; ocr = 0; hi = 0; step(2);

    // R5 / R4: wake and release
    tag = "R5";
    lvl = 0; chg = 1; step(1); chg = 0;
    chk("woken", int'(pd), 0);
    tag = "R4";
    step(5);
    chk("still inhibited below release", int'(dsg_en), 0);
    odr = 0; step(2);
    chk("overdischarge released", int'(dsg_en), 1);

    // R3: second cell, then wake with release already reached
    tag = "R3";
    odr = 2'b10; uv = 2'b10; step(UVD);
    chk("overdischarge trip", int'(pd), 1);
    uv = 0; odr = 0; step(3);
    tag = "R4";
    chg = 1; step(1); chg = 0; step(2);
    chk("released after wake", int'(dsg_en), 1);
    step(5);

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      total++; bad++;
      $display("FAIL watchdog %s: got hang expected finish", tag);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule